// File: doc/BRIEF.md
# Polled Keyboard Register Pair

This block sits on a processor's 16-bit memory bus and answers at two fixed addresses. At those addresses it returns keyboard state instead of memory. The first address is a read-only status word. Its top bit says that a character is waiting. The second address is a data word that carries the character code in its low byte.

Software polls the status word and never blocks. When the top bit is set, software reads the data word. That read consumes the character, and the ready flag drops on the next clock edge.

A keyboard source delivers characters over a byte bus qualified by a valid strobe. A zero byte is not treated as a character. Whenever either register address is on the bus during an access, the block raises a hit signal. The hit signal tells the memory system to stand aside. Accesses to every other address pass through to memory, and the hit stays low.

Top module: `kbd_mmio`

## Requirements
- R1: After a synchronous active-low reset, no character is pending: the status word reads 0x0000 and the data word reads 0x0000.
- R2: A read at address 0xFE00 returns 0x8000 (bit 15 set, all other bits zero) while a character is pending, and 0x0000 otherwise.
- R3: A read at address 0xFE02 returns the latched character code in bits 7:0 with bits 15:8 zero.
- R4: A cycle with the key valid strobe high and a non-zero key byte latches the byte and marks a character pending from the next clock edge.
- R5: A cycle with the key valid strobe high and a zero key byte changes neither the latched character nor the pending flag.
- R6: A read at 0xFE02 clears the pending flag at the next clock edge; a read at 0xFE00 leaves it unchanged.
- R7: A non-zero byte that arrives while a character is still pending replaces the latched character, and the pending flag stays set.
- R8: When a non-zero byte arrives in the same cycle as a read at 0xFE02, the new byte is latched and the pending flag stays set.
- R9: An access at any address other than 0xFE00 or 0xFE02 keeps the hit output low and the read data at zero.
- R10: A write at 0xFE00 or 0xFE02 raises the hit output but changes neither the latched character nor the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 16 | Bus write data (never stored) |
| key_valid | input | 1 | Key byte qualifier |
| key_byte | input | 8 | Incoming character code |
| bus_rdata | output | 16 | Read data for a register hit, zero otherwise |
| bus_hit | output | 1 | High when a register address is accessed; overrides memory |

## Verification
The hardest case is a new key that arrives in the very cycle that software consumes the previous one. In that cycle the clear and the set both compete for the pending flag. The stimulus gets there by driving a data-register read and a valid non-zero byte on the same cycle. It then polls the status word and reads the data word to show that the new character survived.

A related case is a zero byte arriving on top of a pending character. That case checks that the zero byte is ignored without disturbing the pending one.

// File: rtl/kbd_pkg.sv
// Package: shared constants and the register-select type for the keyboard
// register pair. Assumes a 16-bit word-addressed bus.
package kbd_pkg;
    localparam int KBD_ADDR_W = 16;
    localparam int KBD_DATA_W = 16;
    localparam int KBD_CHAR_W = 8;
    localparam logic [KBD_ADDR_W-1:0] KBD_STATUS_ADDR = 16'hFE00;
    localparam logic [KBD_ADDR_W-1:0] KBD_DATA_ADDR   = 16'hFE02;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_DATA   = 2'd2
    } kbd_sel_e;
endpackage

// File: rtl/kbd_addr_decode.sv
// Address decoder: selects the status or data register for the current
// access and raises the hit flag for any access (read or write) at either
// address. Assumes read and write are qualified by their own strobes.
module kbd_addr_decode
    import kbd_pkg::*;
#(
    parameter int ADDR_W = KBD_ADDR_W,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = KBD_STATUS_ADDR,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = KBD_DATA_ADDR
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output kbd_sel_e          sel,
    output logic              hit,
    output logic              consume
);
    // Map the address onto a register select.
    always_comb begin
        if (addr == STATUS_ADDR)    sel = SEL_STATUS;
        else if (addr == DATA_ADDR) sel = SEL_DATA;
        else                        sel = SEL_NONE;
    end

    // Hit on any access to a register; a data read consumes the character.
    always_comb begin
        hit     = (rd || wr) && (sel != SEL_NONE);
        consume = rd && (sel == SEL_DATA);
    end
endmodule

// File: rtl/kbd_capture.sv
// Character capture: latches non-zero key bytes and keeps the pending flag.
// A new byte takes priority over a consume in the same cycle. Reset is
// synchronous, active low.
module kbd_capture #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    input  logic              consume,
    output logic              ready,
    output logic [CHAR_W-1:0] char_q
);
    logic take;

    // A valid, non-zero byte is a real character.
    always_comb take = key_valid && (key_byte != '0);

    // Hold the latest character.
    always_ff @(posedge clk) begin
        if (!rst_n)    char_q <= '0;
        else if (take) char_q <= key_byte;
    end

    // Pending flag: set by a character, cleared by a consume, arrival wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       ready <= 1'b0;
        else if (take)    ready <= 1'b1;
        else if (consume) ready <= 1'b0;
    end
endmodule

// File: rtl/kbd_read_mux.sv
// Read-data mux: forms the status word (ready in the top bit) or the
// zero-extended character, and drives zero on every other access.
// Assumes CHAR_W < DATA_W.
module kbd_read_mux
    import kbd_pkg::*;
#(
    parameter int DATA_W = KBD_DATA_W,
    parameter int CHAR_W = KBD_CHAR_W
) (
    input  kbd_sel_e          sel,
    input  logic              rd,
    input  logic              ready,
    input  logic [CHAR_W-1:0] char_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - CHAR_W;

    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] data_word;

    // Build both register views.
    always_comb begin
        status_word = '0;
        status_word[DATA_W-1] = ready;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            // Zero-extend the character to a bus word.
            always_comb data_word = {{PAD_W{1'b0}}, char_q};
        end else begin : g_nopad
            // Character already fills the bus word.
            always_comb data_word = char_q[DATA_W-1:0];
        end
    endgenerate

    // Select the word for a read; zero otherwise.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_STATUS: rdata = status_word;
                SEL_DATA:   rdata = data_word;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/kbd_mmio.sv
// Top: polled keyboard register pair on the memory bus. The status word sits
// at the first address and the data word at the second. Writes are decoded
// (hit) but discarded. Synchronous active-low reset.
module kbd_mmio
    import kbd_pkg::*;
#(
    parameter int ADDR_W = KBD_ADDR_W,
    parameter int DATA_W = KBD_DATA_W,
    parameter int CHAR_W = KBD_CHAR_W,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = KBD_STATUS_ADDR,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = KBD_DATA_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit
);
    kbd_sel_e          sel;
    logic              consume;
    logic              ready_q;
    logic [CHAR_W-1:0] char_q;
    logic              wdata_unused;

    // Write data is never stored; fold it so it is visibly consumed.
    always_comb wdata_unused = ^bus_wdata;

    kbd_addr_decode #(
        .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .sel(sel), .hit(bus_hit), .consume(consume)
    );

    kbd_capture #(.CHAR_W(CHAR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_byte(key_byte),
        .consume(consume), .ready(ready_q), .char_q(char_q)
    );

    kbd_read_mux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_mux (
        .sel(sel), .rd(bus_rd), .ready(ready_q), .char_q(char_q),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/kbd_mmio_chk.sv
// Checker: temporal properties of the keyboard register pair, bound to the
// top and watching its ports plus the capture state.
module kbd_mmio_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFE02
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              key_valid,
    input logic [CHAR_W-1:0] key_byte,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_hit,
    input logic              ready_q,
    input logic [CHAR_W-1:0] char_q
);
    logic newkey, at_reg, data_rd;
    always_comb begin
        newkey  = key_valid && (key_byte != '0);
        at_reg  = (bus_addr == STATUS_ADDR) || (bus_addr == DATA_ADDR);
        data_rd = bus_rd && (bus_addr == DATA_ADDR);
    end

    // R4: a real character is latched and pending next cycle.
    p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        newkey |=> (ready_q && char_q == $past(key_byte)));

    // R5: a zero byte with no consume changes nothing.
    p_zero_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_byte == '0 && !data_rd) |=> ($stable(ready_q) && $stable(char_q)));

    // R6: a data read without a new byte clears pending.
    p_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !newkey) |=> !ready_q);

    // R2: status read reflects pending in the top bit only.
    p_status_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STATUS_ADDR) |-> (bus_rdata == {ready_q, {(DATA_W-1){1'b0}}}));

    // R3: data read has a zero upper byte.
    p_data_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |-> (bus_rdata[DATA_W-1:CHAR_W] == '0));

    // R9: other addresses are never claimed.
    p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !at_reg |-> (!bus_hit && bus_rdata == '0));

    // R10: a write without a new byte leaves the character unchanged.
    p_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && !newkey) |=> ($stable(char_q) && $stable(ready_q)));
endmodule

bind kbd_mmio kbd_mmio_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
    .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .key_valid(key_valid), .key_byte(key_byte),
    .bus_rdata(bus_rdata), .bus_hit(bus_hit), .ready_q(ready_q), .char_q(char_q)
);

// File: tb/tb_kbd_mmio.sv
// Bench: behavioural model (pending flag plus character) stepped every clock;
// hit and read data compared on every cycle.
module tb_kbd_mmio;
    localparam logic [15:0] ST = 16'hFE00;
    localparam logic [15:0] DT = 16'hFE02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        key_valid = 1'b0;
    logic [7:0]  key_byte = '0;
    logic [15:0] bus_rdata;
    logic        bus_hit;

    int tests = 0, fails = 0;
    bit m_ready = 0;
    logic [7:0] m_char = '0;
    bit done = 0;

    always #10 clk = ~clk;

    kbd_mmio dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .key_valid(key_valid),
        .key_byte(key_byte), .bus_rdata(bus_rdata), .bus_hit(bus_hit)
    );

    // One bus cycle: drive, compare against the model, clock, step the model.
    task automatic cyc(input logic [15:0] a, input bit rd, input bit wr,
                       input bit kv, input logic [7:0] kb, input string tag);
        logic [15:0] e_rd;
        bit e_hit;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = 16'hA5C3;
        key_valid = kv; key_byte = kb;
        #1;
        e_hit = (rd || wr) && (a == ST || a == DT);
        e_rd  = 16'h0;
        if (rd && a == ST) e_rd = m_ready ? 16'h8000 : 16'h0000;
        if (rd && a == DT) e_rd = {8'h00, m_char};
        tests++;
        if (bus_hit !== e_hit || bus_rdata !== e_rd) begin
            fails++;
            $display("FAIL %s: hit=%0b rdata=%h expected hit=%0b rdata=%h",
                     tag, bus_hit, bus_rdata, e_hit, e_rd);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_ready = 0; m_char = '0;
        end else if (kv && kb != 8'h00) begin
            m_ready = 1; m_char = kb;
        end else if (rd && a == DT) begin
            m_ready = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        cyc(16'h0000, 0, 0, 1, 8'h41, "R1");
        cyc(16'h0000, 0, 0, 0, 8'h00, "R1");
        rst_n = 1'b1;
        cyc(ST, 1, 0, 0, 8'h00, "R1 status after reset");
        cyc(DT, 1, 0, 0, 8'h00, "R1 data after reset");
        cyc(16'h3000, 0, 0, 1, 8'h48, "R4 key arrives");
        cyc(ST, 1, 0, 0, 8'h00, "R2 status pending");
        cyc(ST, 1, 0, 0, 8'h00, "R6 status read keeps pending");
        cyc(DT, 1, 0, 0, 8'h00, "R3 data read");
        cyc(ST, 1, 0, 0, 8'h00, "R6 cleared after data read");
        cyc(16'h1234, 0, 0, 1, 8'h00, "R5 zero byte, idle");
        cyc(ST, 1, 0, 0, 8'h00, "R5 still not pending");
        cyc(DT, 1, 0, 0, 8'h00, "R5 char unchanged");
        cyc(16'h0000, 0, 0, 1, 8'hFF, "R4 key 0xFF");
        cyc(16'h0000, 0, 0, 1, 8'h00, "R5 zero byte while pending");
        cyc(ST, 1, 0, 1, 8'h62, "R7 overwrite while pending");
        cyc(ST, 1, 0, 0, 8'h00, "R7 still pending");
        cyc(DT, 1, 0, 1, 8'h7A, "R8 key during data read");
        cyc(ST, 1, 0, 0, 8'h00, "R8 pending survives");
        cyc(DT, 0, 1, 0, 8'h00, "R10 write data reg");
        cyc(ST, 0, 1, 0, 8'h00, "R10 write status reg");
        cyc(ST, 1, 0, 0, 8'h00, "R10 pending unchanged");
        cyc(DT, 1, 0, 0, 8'h00, "R10 char unchanged");
        cyc(ST, 1, 0, 0, 8'h00, "R6 cleared");
        cyc(16'hFE01, 1, 0, 1, 8'h31, "R9 neighbour address");
        cyc(16'hFE04, 1, 0, 0, 8'h00, "R9 other read");
        cyc(16'h3000, 0, 1, 0, 8'h00, "R9 other write");
        cyc(16'hFDFE, 1, 0, 0, 8'h00, "R9 below");
        cyc(DT, 1, 0, 0, 8'h00, "R3 char 0x31");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule